// File: doc/BRIEF.md
# Memory Block Decoder with Shadow ROM

This block maps every processor memory cycle onto on-board RAM, on-board ROM or the external bus. The 64K memory space is cut into eight 8K blocks, selected by the top three address bits. Each block is configured by two static bits: a RAM enable and a ROM enable. The four settings give four behaviours: pass the cycle to the external bus, plain RAM, ROM that reads from ROM but sends writes to RAM, and a shadow overlay.

A shadow block acts like a ROM block while the overlay is active. Once the overlay is killed, the block acts like RAM. The block holds the kill state and resets it so that the overlay is active. A static source select chooses between two kill sources. The first is a one-shot latch that is set the first time the storage-card select register is written with 0. The second is bit 0 of a parallel output register, which software can set and clear. The ROM is 32K, so its address is the lower 15 address bits, and the upper half of the map mirrors the lower half.

Top module: `mem_block_decode`

## Requirements
- R1: Bits 15..13 of `addr_i` pick the block, and block n uses configuration bits `ram_en_i[n]` and `rom_en_i[n]`.
- R2: When a block has both enables at 0, any read or write raises `ext_o`, and `ram_cs_o`, `rom_cs_o`, `ram_we_o` and `rom_oe_o` stay low.
- R3: When a block has only the RAM enable set, a read raises `ram_cs_o` alone, and a write raises `ram_cs_o` and `ram_we_o`.
- R4: When a block has only the ROM enable set, a read raises `rom_cs_o` and `rom_oe_o`, and a write raises `ram_cs_o` and `ram_we_o`. A write never raises `rom_cs_o`.
- R5: When a block has both enables set and the overlay is active, the block behaves as in R4.
- R6: When a block has both enables set and the overlay is killed, the block behaves as in R3.
- R7: After reset the overlay is active, the one-shot latch is clear and the port bit is 0.
- R8: With `kill_src_i`=0, a clock edge with `card_sel_wr_i`=1 and `card_sel_d_i`=0 kills the overlay from the next cycle on. Later writes of 1 do not restore it, and only reset restores it.
- R9: With `kill_src_i`=1, a clock edge with `port_wr_i`=1 loads `port_d0_i` as the kill bit (1 = kill). The new value takes effect from the next cycle, so the overlay can be switched back in.
- R10: The kill source not selected by `kill_src_i` has no effect on the routing.
- R11: With `mem_rd_i` and `mem_wr_i` both low, all select outputs are low.
- R12: `rom_addr_o` always equals `addr_i[14:0]`, so the upper 32K mirrors the lower 32K.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Memory address |
| mem_rd_i | input | 1 | Memory read cycle |
| mem_wr_i | input | 1 | Memory write cycle (wins if both are high) |
| ram_en_i | input | 8 | Per-block RAM enable |
| rom_en_i | input | 8 | Per-block ROM enable |
| kill_src_i | input | 1 | Kill source: 0 = one-shot on card select, 1 = port bit |
| card_sel_wr_i | input | 1 | Write strobe of the card select register |
| card_sel_d_i | input | 1 | Card select data bit (0 = select) |
| port_wr_i | input | 1 | Write strobe of the parallel output register |
| port_d0_i | input | 1 | Bit 0 of the parallel output data |
| ram_cs_o | output | 1 | RAM chip select |
| rom_cs_o | output | 1 | ROM chip select |
| ram_we_o | output | 1 | RAM write enable |
| rom_oe_o | output | 1 | ROM output enable |
| ext_o | output | 1 | Cycle goes to the external bus |
| rom_addr_o | output | 15 | ROM address |

## Verification
The only state in the block is the kill state. If it is wrong, the fault shows at the ports on the next read of a shadow block: `rom_cs_o` rises where `ram_cs_o` is expected, or the other way round. That happens in the first cycle after the write that should have changed the state. Writes never separate the two states, so the bench reads a shadow block right after every kill-source write. A wrong decode of the block index or of a mode shows up at once, in the same cycle, as the wrong chip select. To catch it, the bench sweeps every block with both a read and a write.

// File: rtl/mem_decode_pkg.sv
package mem_decode_pkg;
  typedef enum logic [1:0] {
    MODE_EXT = 2'b00,
    MODE_RAM = 2'b01,
    MODE_ROM = 2'b10,
    MODE_SHD = 2'b11
  } blk_mode_e;
endpackage

// File: rtl/shadow_kill_ctl.sv
module shadow_kill_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kill_src_i,
  input  logic card_sel_wr_i,
  input  logic card_sel_d_i,
  input  logic port_wr_i,
  input  logic port_d0_i,
  output logic kill_o
);
  logic oneshot_q, port_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oneshot_q <= 1'b0;
      port_q    <= 1'b0;
    end else begin
      if (card_sel_wr_i && !card_sel_d_i) oneshot_q <= 1'b1;
      if (port_wr_i) port_q <= port_d0_i;
    end
  end

  assign kill_o = kill_src_i ? port_q : oneshot_q;

  AST_ONESHOT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oneshot_q |=> oneshot_q); // R8
  AST_PORT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_wr_i |=> (port_q == $past(port_d0_i))); // R9
endmodule

// File: rtl/blk_mode_table.sv
module blk_mode_table
  import mem_decode_pkg::*;
#(
  parameter int BLK_W   = 3,
  localparam int NUM_BLK = 1 << BLK_W
) (
  input  logic [NUM_BLK-1:0] ram_en_i,
  input  logic [NUM_BLK-1:0] rom_en_i,
  input  logic [BLK_W-1:0]   blk_i,
  output blk_mode_e          mode_o
);
  blk_mode_e modes [NUM_BLK];

  for (genvar g = 0; g < NUM_BLK; g++) begin : g_blk
    assign modes[g] = blk_mode_e'({rom_en_i[g], ram_en_i[g]});
  end

  assign mode_o = modes[blk_i];
endmodule

// File: rtl/access_steer.sv
module access_steer
  import mem_decode_pkg::*;
(
  input  blk_mode_e mode_i,
  input  logic      kill_i,
  input  logic      rd_i,
  input  logic      wr_i,
  output logic      ram_cs_o,
  output logic      rom_cs_o,
  output logic      ram_we_o,
  output logic      rom_oe_o,
  output logic      ext_o
);
  logic rd_only, rom_reads;

  assign rd_only   = rd_i && !wr_i;
  // ROM reads in ROM mode, and in shadow mode while the overlay lives
  assign rom_reads = (mode_i == MODE_ROM) || (mode_i == MODE_SHD && !kill_i);

  always_comb begin
    ram_cs_o = 1'b0;
    rom_cs_o = 1'b0;
    ram_we_o = 1'b0;
    rom_oe_o = 1'b0;
    ext_o    = 1'b0;
    if (mode_i == MODE_EXT) begin
      ext_o = rd_i || wr_i;
    end else if (wr_i) begin
      ram_cs_o = 1'b1;
      ram_we_o = 1'b1;
    end else if (rd_only) begin
      rom_cs_o = rom_reads;
      rom_oe_o = rom_reads;
      ram_cs_o = !rom_reads;
    end
  end
endmodule

// File: rtl/mem_block_decode.sv
module mem_block_decode
  import mem_decode_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BLK_W  = 3,
  parameter int ROM_AW = 15,
  localparam int NUM_BLK = 1 << BLK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              mem_rd_i,
  input  logic              mem_wr_i,
  input  logic [NUM_BLK-1:0] ram_en_i,
  input  logic [NUM_BLK-1:0] rom_en_i,
  input  logic              kill_src_i,
  input  logic              card_sel_wr_i,
  input  logic              card_sel_d_i,
  input  logic              port_wr_i,
  input  logic              port_d0_i,
  output logic              ram_cs_o,
  output logic              rom_cs_o,
  output logic              ram_we_o,
  output logic              rom_oe_o,
  output logic              ext_o,
  output logic [ROM_AW-1:0] rom_addr_o
);
  logic      kill;
  blk_mode_e mode;

  shadow_kill_ctl u_kill (
    .clk_i(clk_i), .rst_ni(rst_ni), .kill_src_i(kill_src_i),
    .card_sel_wr_i(card_sel_wr_i), .card_sel_d_i(card_sel_d_i),
    .port_wr_i(port_wr_i), .port_d0_i(port_d0_i), .kill_o(kill)
  );

  blk_mode_table #(.BLK_W(BLK_W)) u_tbl (
    .ram_en_i(ram_en_i), .rom_en_i(rom_en_i),
    .blk_i(addr_i[ADDR_W-1 -: BLK_W]), .mode_o(mode)
  );

  access_steer u_steer (
    .mode_i(mode), .kill_i(kill), .rd_i(mem_rd_i), .wr_i(mem_wr_i),
    .ram_cs_o(ram_cs_o), .rom_cs_o(rom_cs_o), .ram_we_o(ram_we_o),
    .rom_oe_o(rom_oe_o), .ext_o(ext_o)
  );

  // ROM is half the map: upper half mirrors lower
  assign rom_addr_o = addr_i[ROM_AW-1:0];

  AST_ONE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ram_cs_o, rom_cs_o, ext_o})); // R2
  AST_ROM_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_i |-> !rom_cs_o && !rom_oe_o); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_rd_i && !mem_wr_i) |-> !(ram_cs_o || rom_cs_o || ext_o || ram_we_o)); // R11
  AST_WE_WITH_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> ram_cs_o && mem_wr_i); // R3
endmodule

// File: tb/mem_block_decode_tb_top.sv
module mem_block_decode_tb_top;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [15:0] addr_i = '0;
  logic mem_rd_i = 0, mem_wr_i = 0;
  logic [7:0] ram_en_i = '0, rom_en_i = '0;
  logic kill_src_i = 0, card_sel_wr_i = 0, card_sel_d_i = 1, port_wr_i = 0, port_d0_i = 0;
  logic ram_cs_o, rom_cs_o, ram_we_o, rom_oe_o, ext_o;
  logic [14:0] rom_addr_o;

  int checks = 0, fails = 0;
  bit m_os = 0, m_port = 0;  // reference kill state
  bit done = 0;

  always #10 clk_i = ~clk_i;

  mem_block_decode dut_i (.*);

  task automatic check(input logic [4:0] act, exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%b exp=%b (ram_cs rom_cs ram_we rom_oe ext)", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] model(input logic [15:0] a, input bit rd, wr);
    int blk = int'(a[15:13]);
    bit kill = kill_src_i ? m_port : m_os;
    bit re = ram_en_i[blk], ro = rom_en_i[blk];
    if (!rd && !wr) return 5'b0;
    if (!re && !ro) return 5'b00001;
    if (wr) return 5'b10100;
    if (ro && (!re || !kill)) return 5'b01010;
    return 5'b10000;
  endfunction

  // one clock: drive at negedge, compare mid-low, update model at posedge
  task automatic step(input logic [15:0] a, input bit rd, wr, cw, cd, pw, pd, input string tag);
    @(negedge clk_i);
    addr_i = a; mem_rd_i = rd; mem_wr_i = wr;
    card_sel_wr_i = cw; card_sel_d_i = cd; port_wr_i = pw; port_d0_i = pd;
    #5;
    check({ram_cs_o, rom_cs_o, ram_we_o, rom_oe_o, ext_o}, model(a, rd, wr), tag);
    checks++;
    if (rom_addr_o !== a[14:0]) begin
      fails++;
      $display("FAIL R12: act=%h exp=%h", rom_addr_o, a[14:0]);
    end
    @(posedge clk_i);
    if (cw && !cd) m_os = 1;
    if (pw) m_port = pd;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 0; mem_rd_i = 0; mem_wr_i = 0; card_sel_wr_i = 0; port_wr_i = 0;
    m_os = 0; m_port = 0;
    #5;
    check({ram_cs_o, rom_cs_o, ram_we_o, rom_oe_o, ext_o}, 5'b0, "R7 reset idle");
    @(negedge clk_i);
    rst_ni = 1;
  endtask

  initial begin
    // blocks: 0/4 shadow, 1/5 RAM, 2/6 ROM, 3/7 external
    ram_en_i = 8'b0011_0011;
    rom_en_i = 8'b0101_0101;
    do_reset();
    for (int b = 0; b < 8; b++) begin  // R1 R2 R3 R4 R5
      step({b[2:0], 13'h0155}, 1, 0, 0, 1, 0, 0, "R1 read sweep");
      step({b[2:0], 13'h1aa0}, 0, 1, 0, 1, 0, 0, "R1 write sweep");
      step({b[2:0], 13'h0042}, 0, 0, 0, 1, 0, 0, "R11 idle");
    end
    step(16'h0010, 1, 0, 0, 1, 0, 0, "R7 shadow active after reset");
    // one-shot kill: port writes ignored (R10)
    step(16'h0010, 0, 0, 0, 1, 1, 1, "R10 port write in one-shot mode");
    step(16'h0010, 1, 0, 0, 1, 0, 0, "R10 shadow still active");
    step(16'h0010, 1, 0, 1, 1, 0, 0, "R8 write 1 keeps overlay");
    step(16'h8010, 1, 0, 1, 0, 0, 0, "R8 kill write cycle");
    step(16'h8010, 1, 0, 0, 1, 0, 0, "R6 killed reads RAM");
    step(16'h0020, 1, 0, 1, 1, 0, 0, "R8 write 1 does not restore");
    step(16'h0020, 1, 0, 0, 1, 0, 0, "R8 still killed");
    step(16'h4020, 1, 0, 0, 1, 0, 0, "R4 ROM block unaffected by kill");
    do_reset();
    step(16'h0030, 1, 0, 0, 1, 0, 0, "R7 reset restores overlay");
    // port-controlled kill
    @(negedge clk_i); kill_src_i = 1;
    step(16'h0030, 1, 0, 1, 0, 0, 0, "R10 card select ignored in port mode");
    step(16'h0030, 1, 0, 0, 1, 0, 0, "R10 overlay still active");
    step(16'h8030, 1, 0, 0, 1, 1, 1, "R9 port kill write");
    step(16'h8030, 1, 0, 0, 1, 0, 0, "R9 killed by port");
    step(16'h8030, 0, 1, 0, 1, 0, 0, "R6 write in killed shadow");
    step(16'h0040, 1, 0, 0, 1, 1, 0, "R9 port restore write");
    step(16'h0040, 1, 0, 0, 1, 0, 0, "R9 overlay restored");
    step(16'h0040, 1, 1, 0, 1, 0, 0, "R5 write wins over read");
    // all external
    @(negedge clk_i); ram_en_i = '0; rom_en_i = '0;
    for (int b = 0; b < 8; b++) step({b[2:0], 13'h0777}, 1, 0, 0, 1, 0, 0, "R2 all external");
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin @(posedge clk_i); cyc++; end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: act=timeout exp=done");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule